// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block decides which of eight interrupt request lines, if any, should be presented to the processor. It takes the pending request vector, the mask vector, the in-service vector, a 3-bit rotation base and three mode flags. From these it produces a registered valid flag and the 3-bit number of the winning line. Priority is not fixed to line 0. The line equal to the rotation base ranks highest, and rank falls off going upward through the line numbers, wrapping from 7 back to 0.

A pending, unmasked request wins only when it ranks strictly above every line still being serviced. This gives the nesting behaviour of a classic interrupt controller. Two modes change which in-service lines count. In special mask mode, masked in-service lines are ignored. When the unit acts as the primary controller with fully nested mode on, the in-service bit of the cascade line is ignored, so a secondary controller behind that line can interrupt again. Programming, acknowledge handling and cascading live in the surrounding logic. This block only resolves the winner, with one clock of latency.

Top module: `irq_rank_resolver`

## Requirements
- R1: While `rst` is high at a clock edge, the following cycle shows `win_valid` = 0 and `win_line` = 0.
- R2: When no request survives masking (`req & ~mask` is zero), the next cycle shows `win_valid` = 0 and `win_line` = 0.
- R3: With nothing in service, the winner is the first line that is set in `req & ~mask` when scanning from line `base` upward modulo 8. `win_line` gives its line number (relative rank + base) mod 8.
- R4: A line whose `mask` bit is 1 is never reported, and a reported line always had its `req` bit set.
- R5: A candidate is reported only if its rank relative to `base` is strictly better than that of the best-ranked counted in-service line. A request on a line that is itself counted as in service, or one ranked below it, yields `win_valid` = 0.
- R6: When `spec_mask_en` = 1, in-service lines whose `mask` bit is 1 are left out of the in-service rank. When it is 0, they count.
- R7: When `nest_en` = 1 and `is_primary` = 1, the in-service bit of line 2 (the cascade line, parameter `CASCADE_LINE`) is left out of the in-service rank. With either flag at 0, it counts.
- R8: Outputs change only at a clock edge and reflect the inputs sampled at that edge. Inputs held steady over two edges give steady outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 8 | Pending request per line |
| mask | input | 8 | Mask per line, 1 blocks the line |
| insvc | input | 8 | In-service bit per line |
| base | input | 3 | Highest-priority line (rotation base) |
| spec_mask_en | input | 1 | Drop masked lines from the in-service rank |
| nest_en | input | 1 | Fully nested mode flag |
| is_primary | input | 1 | Unit is the primary controller of a cascade |
| win_valid | output | 1 | A request beats the in-service level |
| win_line | output | 3 | Line number of the winner, 0 when none |

## Verification
A wrong rotation or encoder state shows up as the wrong line number on `win_line` one edge after the inputs are applied. Only base values other than zero expose a rotation error, so the tests sweep the base. Errors in the in-service filter show as `win_valid` being asserted or withheld wrongly on the next cycle. These errors appear only when the in-service rank and the candidate rank are close, so directed cases place them next to each other, on the same line, and across the wrap point. A random sweep then compares every cycle against a loop model.

// File: rtl/irq_rank_pkg.sv
package irq_rank_pkg;
  localparam int unsigned DEF_LINES   = 8;
  localparam int unsigned DEF_CASCADE = 2;
endpackage

// File: rtl/irq_vec_rotate.sv
module irq_vec_rotate #(
  parameter int unsigned N  = irq_rank_pkg::DEF_LINES,
  parameter int unsigned SW = $clog2(N)
) (
  input  logic [N-1:0]  vec_in,
  input  logic [SW-1:0] amt,
  output logic [N-1:0]  vec_out
);
  // position i of the output holds line (i + amt) mod N
  always_comb begin
    for (int i = 0; i < N; i++) begin
      int unsigned src;
      src = i + int'(amt);
      if (src >= N) src = src - N;
      vec_out[i] = vec_in[src];
    end
  end
endmodule

// File: rtl/irq_first_set.sv
module irq_first_set #(
  parameter int unsigned N  = irq_rank_pkg::DEF_LINES,
  parameter int unsigned PW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec_in,
  output logic [PW-1:0] rank
);
  // lowest set index, or N when the vector is empty
  always_comb begin
    rank = PW'(N);
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_in[i]) rank = PW'(i);
    end
  end
endmodule

// File: rtl/irq_rank_resolver.sv
module irq_rank_resolver #(
  parameter int unsigned N            = irq_rank_pkg::DEF_LINES,
  parameter int unsigned CASCADE_LINE = irq_rank_pkg::DEF_CASCADE,
  localparam int unsigned SW          = $clog2(N),
  localparam int unsigned PW          = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  mask,
  input  logic [N-1:0]  insvc,
  input  logic [SW-1:0] base,
  input  logic          spec_mask_en,
  input  logic          nest_en,
  input  logic          is_primary,
  output logic          win_valid,
  output logic [SW-1:0] win_line
);
  localparam logic [N-1:0] CASC_BIT = N'(1) << CASCADE_LINE;

  logic [N-1:0]  cand_vec, svc_vec;
  logic [N-1:0]  cand_rot, svc_rot;
  logic [PW-1:0] cand_rank, svc_rank;
  logic [PW:0]   line_sum, line_mod;
  logic          next_valid;
  logic [SW-1:0] next_line;

  // candidates and the filtered in-service set
  always_comb begin
    cand_vec = req & ~mask;
    svc_vec  = insvc;
    if (spec_mask_en)          svc_vec = svc_vec & ~mask;
    if (nest_en && is_primary) svc_vec = svc_vec & ~CASC_BIT;
  end

  irq_vec_rotate #(.N(N), .SW(SW)) u_rot_cand (
    .vec_in (cand_vec),
    .amt    (base),
    .vec_out(cand_rot)
  );

  irq_vec_rotate #(.N(N), .SW(SW)) u_rot_svc (
    .vec_in (svc_vec),
    .amt    (base),
    .vec_out(svc_rot)
  );

  irq_first_set #(.N(N), .PW(PW)) u_enc_cand (
    .vec_in(cand_rot),
    .rank  (cand_rank)
  );

  irq_first_set #(.N(N), .PW(PW)) u_enc_svc (
    .vec_in(svc_rot),
    .rank  (svc_rank)
  );

  // map relative rank back to an absolute line number
  always_comb begin
    line_sum   = (PW+1)'(cand_rank) + (PW+1)'(base);
    line_mod   = (line_sum >= (PW+1)'(N)) ? line_sum - (PW+1)'(N) : line_sum;
    next_valid = (cand_rank < svc_rank);
    next_line  = next_valid ? line_mod[SW-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_valid <= 1'b0;
      win_line  <= '0;
    end else begin
      win_valid <= next_valid;
      win_line  <= next_line;
    end
  end
endmodule

// File: rtl/irq_rank_resolver_chk.sv
module irq_rank_resolver_chk #(
  parameter int unsigned N            = 8,
  parameter int unsigned CASCADE_LINE = 2,
  parameter int unsigned SW           = $clog2(N)
) (
  input logic          clk,
  input logic          rst,
  input logic [N-1:0]  req,
  input logic [N-1:0]  mask,
  input logic [N-1:0]  insvc,
  input logic [SW-1:0] base,
  input logic          spec_mask_en,
  input logic          nest_en,
  input logic          is_primary,
  input logic          win_valid,
  input logic [SW-1:0] win_line
);
  // R2
  no_cand_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((req & ~mask) == '0) |=> (!win_valid && win_line == '0));

  // R4
  masked_never_wins_chk: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> ((($past(mask) >> win_line) & N'(1)) == '0));

  // R4
  winner_was_pending_chk: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> ((($past(req) >> win_line) & N'(1)) != '0));

  // R5
  not_already_served_chk: assert property (@(posedge clk) disable iff (rst)
    (win_valid && !($past(nest_en && is_primary) && win_line == SW'(CASCADE_LINE)))
      |-> ((($past(insvc) >> win_line) & N'(1)) == '0));

  // R8
  steady_in_steady_out_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(req) && $stable(mask) && $stable(insvc) && $stable(base)
      && $stable(spec_mask_en) && $stable(nest_en) && $stable(is_primary))
      |=> ($stable(win_valid) && $stable(win_line)));
endmodule

bind irq_rank_resolver irq_rank_resolver_chk #(
  .N(N), .CASCADE_LINE(CASCADE_LINE), .SW(SW)
) u_chk (
  .clk(clk), .rst(rst), .req(req), .mask(mask), .insvc(insvc), .base(base),
  .spec_mask_en(spec_mask_en), .nest_en(nest_en), .is_primary(is_primary),
  .win_valid(win_valid), .win_line(win_line)
);

// File: tb/irq_rank_resolver_test.sv
module irq_rank_resolver_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] req = '0, mask = '0, insvc = '0;
  logic [2:0] base = '0;
  logic       spec_mask_en = 1'b0, nest_en = 1'b0, is_primary = 1'b0;
  logic       win_valid;
  logic [2:0] win_line;
  int         n_checks = 0, n_fail = 0;

  always #10 clk = ~clk;

  irq_rank_resolver uut (
    .clk(clk), .rst(rst), .req(req), .mask(mask), .insvc(insvc), .base(base),
    .spec_mask_en(spec_mask_en), .nest_en(nest_en), .is_primary(is_primary),
    .win_valid(win_valid), .win_line(win_line)
  );

  function automatic logic [3:0] ref_pick(input logic [7:0] rq, mk, is,
      input logic [2:0] b, input logic sm, ne, pr);
    logic [7:0] cand, svc;
    int cp, rp;
    cand = rq & ~mk;
    svc  = is;
    if (sm) svc = svc & ~mk;
    if (ne && pr) svc[2] = 1'b0;
    cp = 8; rp = 8;
    for (int k = 7; k >= 0; k--) begin
      if (svc[(k + b) & 7])  cp = k;
      if (cand[(k + b) & 7]) rp = k;
    end
    if (rp < cp) return {1'b1, 3'((rp + b) & 7)};
    return 4'b0000;
  endfunction

  task automatic chk(input string tag, input logic ev, input logic [2:0] el);
    n_checks++;
    if (win_valid !== ev || win_line !== el) begin
      n_fail++;
      $display("FAIL %s actual valid=%0b line=%0d expected valid=%0b line=%0d",
               tag, win_valid, win_line, ev, el);
    end
  endtask

  // drive at negedge, result visible at the next negedge
  task automatic apply(input logic [7:0] rq, mk, is, input logic [2:0] b,
                       input logic sm, ne, pr);
    req = rq; mask = mk; insvc = is; base = b;
    spec_mask_en = sm; nest_en = ne; is_primary = pr;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    apply(8'hFF, 8'h00, 8'h00, 3'd0, 0, 0, 0);
    chk("R1 reset", 1'b0, 3'd0);
    rst = 1'b0;
    apply(8'h00, 8'h00, 8'h00, 3'd0, 0, 0, 0);
  endtask

  task automatic t_rank;
    apply(8'b0010_0100, 8'h00, 8'h00, 3'd0, 0, 0, 0); chk("R3 base0", 1, 3'd2);
    apply(8'b0010_0100, 8'h00, 8'h00, 3'd3, 0, 0, 0); chk("R3 base3", 1, 3'd5);
    apply(8'b0010_0100, 8'h00, 8'h00, 3'd6, 0, 0, 0); chk("R3 wrap", 1, 3'd2);
    apply(8'h01, 8'h00, 8'h00, 3'd1, 0, 0, 0);        chk("R3 lowest rank", 1, 3'd0);
    apply(8'h81, 8'h00, 8'h00, 3'd7, 0, 0, 0);        chk("R3 base7", 1, 3'd7);
  endtask

  task automatic t_mask;
    apply(8'hFF, 8'hFF, 8'h00, 3'd0, 0, 0, 0); chk("R2 all masked", 0, 3'd0);
    apply(8'h0C, 8'h04, 8'h00, 3'd0, 0, 0, 0); chk("R4 masked skipped", 1, 3'd3);
    apply(8'h00, 8'h00, 8'h00, 3'd5, 0, 0, 0); chk("R2 no request", 0, 3'd0);
  endtask

  task automatic t_strict;
    apply(8'h10, 8'h00, 8'h08, 3'd0, 0, 0, 0); chk("R5 lower rank", 0, 3'd0);
    apply(8'h08, 8'h00, 8'h08, 3'd0, 0, 0, 0); chk("R5 equal rank", 0, 3'd0);
    apply(8'h04, 8'h00, 8'h08, 3'd0, 0, 0, 0); chk("R5 higher rank", 1, 3'd2);
    apply(8'h20, 8'h00, 8'h01, 3'd4, 0, 0, 0); chk("R5 rotated", 1, 3'd5);
  endtask

  task automatic t_spmask;
    apply(8'h40, 8'h02, 8'h02, 3'd0, 0, 0, 0); chk("R6 off", 0, 3'd0);
    apply(8'h40, 8'h02, 8'h02, 3'd0, 1, 0, 0); chk("R6 on", 1, 3'd6);
  endtask

  task automatic t_nested;
    apply(8'h10, 8'h00, 8'h04, 3'd0, 0, 1, 1); chk("R7 primary nested", 1, 3'd4);
    apply(8'h04, 8'h00, 8'h04, 3'd0, 0, 1, 1); chk("R7 cascade reenter", 1, 3'd2);
    apply(8'h10, 8'h00, 8'h04, 3'd0, 0, 1, 0); chk("R7 secondary", 0, 3'd0);
    apply(8'h10, 8'h00, 8'h04, 3'd0, 0, 0, 1); chk("R7 nest off", 0, 3'd0);
  endtask

  task automatic t_latency;
    apply(8'h40, 8'h00, 8'h00, 3'd0, 0, 0, 0); chk("R8 setup", 1, 3'd6);
    req = 8'h00;
    #5;
    chk("R8 held until edge", 1, 3'd6);
    @(negedge clk);
    chk("R8 after edge", 0, 3'd0);
  endtask

  task automatic t_random;
    for (int n = 0; n < 600; n++) begin
      logic [7:0] rq, mk, is;
      logic [2:0] b;
      logic sm, ne, pr;
      logic [3:0] e;
      rq = 8'($urandom); mk = 8'($urandom) & 8'($urandom); is = 8'($urandom) & 8'($urandom);
      b = 3'($urandom); sm = 1'($urandom); ne = 1'($urandom); pr = 1'($urandom);
      e = ref_pick(rq, mk, is, b, sm, ne, pr);
      apply(rq, mk, is, b, sm, ne, pr);
      chk("R3/R5 random", e[3], e[2:0]);
    end
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset;
    t_rank;
    t_mask;
    t_strict;
    t_spmask;
    t_nested;
    t_latency;
    t_random;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule